// File: doc/BRIEF.md
# Prioritised Bank Address Decoder

This block steers each bus request to one of four slave banks. Banks 0, 1 and 2 each own a programmable window. A window is set by a base address, a size given as a power of two, and an enable bit. The base must be aligned to the window size, so a hit reduces to a masked compare of the upper address bits. Bank 3 has no window. It catches every address that no enabled window claims. When windows overlap, the bank with the smallest index takes the request. A write that lands in the upper half of bank 0's window is marked as a forced-immediate write, so that it goes straight to the slave and skips any write buffer.

Requests enter on a valid/ready stream that carries an address and a write flag. The decoded result leaves one cycle later on a second valid/ready stream. That result holds a one-hot chip-select vector, where bit i selects bank i, the forced-immediate flag, and the original address and write flag. The block holds one result in a register. When downstream holds `out_ready` low, the result is frozen and `in_ready` drops. Back-pressure therefore reaches upstream within the same cycle.

Windows are loaded through a plain write port: `win_we`, `win_idx`, `win_en`, `win_base` and `win_szlog`. A write changes only the bank named by `win_idx`. It applies to requests accepted on later clock edges. A write that names index 3 has no effect.

Top module: `bank_addr_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. All windows are disabled, so every request is steered to bank 3 (`out_cs` = 4'b1000).
- R2: A request accepted on a clock edge (`in_valid` and `in_ready` both 1) produces its result from that edge on. `out_valid` is 1 and `out_cs` has exactly one bit set.
- R3: Bank i (i = 0..2) matches when it is enabled and `in_addr` and `win_base` agree on every bit at position `win_szlog` and above. The window therefore spans 2^`win_szlog` bytes.
- R4: When several enabled windows match, the chip select of the lowest-numbered matching bank is the one asserted.
- R5: An address that matches no enabled window selects bank 3.
- R6: A disabled bank never asserts its chip select, even when the address lies inside its stored window.
- R7: `out_force_imm` is 1 only when all three of these hold: the request is a write (`in_write`=1), it selects bank 0, and address bit (`win_szlog` of bank 0) − 1 is 1. Reads never set it.
- R8: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values and `in_ready` is 0.
- R9: While `out_valid` is 0, `out_cs` is all zero and `out_force_imm` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_we | input | 1 | Window register write strobe |
| win_idx | input | 2 | Bank index that the write updates (3 is ignored) |
| win_en | input | 1 | Enable bit that is written |
| win_base | input | 32 | Window base address that is written |
| win_szlog | input | 5 | log2 of the window size that is written |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_addr | input | 32 | Request address |
| in_write | input | 1 | 1 = write, 0 = read |
| out_valid | output | 1 | Decoded result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_cs | output | 4 | One-hot chip select, bit i = bank i |
| out_force_imm | output | 1 | Write must bypass the write buffer |
| out_addr | output | 32 | Address of the result |
| out_write | output | 1 | Write flag of the result |

## Verification
Every decode result appears one register stage after the request is accepted. The bench raises `in_valid` on a falling edge and lets one rising edge accept the request. It then samples `out_cs` and `out_force_imm` on the next falling edge. A window write likewise takes one rising edge to land, and the bench issues it before any request that depends on it. For back-pressure, the bench checks across two further edges that the stalled result and `in_ready` stay put. It then checks that the queued request appears after the first edge with `out_ready` high.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
  localparam int DEC_ADDR_W = 32;
  localparam int DEC_NBANK  = 4;
endpackage

// File: rtl/bank_window_regs.sv
module bank_window_regs #(
  parameter int ADDR_W = 32,
  parameter int NWIN   = 3,
  parameter int IDX_W  = 2,
  parameter int SZ_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              en_in,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [SZ_W-1:0]   szlog_in,
  output logic [NWIN-1:0]   win_en,
  output logic [ADDR_W-1:0] win_base  [NWIN],
  output logic [SZ_W-1:0]   win_szlog [NWIN]
);
  for (genvar w = 0; w < NWIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_en[w]    <= 1'b0;
        win_base[w]  <= '0;
        win_szlog[w] <= '0;
      end else if (we && (int'(idx) == w)) begin
        win_en[w]    <= en_in;
        win_base[w]  <= base_in;
        win_szlog[w] <= szlog_in;
      end
    end
  end
endmodule

// File: rtl/bank_window_match.sv
module bank_window_match #(
  parameter int ADDR_W = 32,
  parameter int NWIN   = 3,
  parameter int SZ_W   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NWIN-1:0]   win_en,
  input  logic [ADDR_W-1:0] win_base  [NWIN],
  input  logic [SZ_W-1:0]   win_szlog [NWIN],
  output logic [NWIN-1:0]   hit,
  output logic [NWIN-1:0]   upper
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  for (genvar w = 0; w < NWIN; w++) begin : g_cmp
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] half_bit;
    always_comb begin
      keep_mask = {ADDR_W{1'b1}} << win_szlog[w];
      half_bit  = (ONE << win_szlog[w]) >> 1;
      hit[w]    = win_en[w] && (((addr ^ win_base[w]) & keep_mask) == '0);
      upper[w]  = |(addr & half_bit);
    end
  end
endmodule

// File: rtl/bank_priority_pick.sv
module bank_priority_pick #(
  parameter int NBANK = 4
) (
  input  logic [NBANK-2:0] hit,
  output logic [NBANK-1:0] sel
);
  always_comb begin
    sel = '0;
    sel[NBANK-1] = 1'b1;
    for (int b = NBANK - 2; b >= 0; b--) begin
      if (hit[b]) begin
        sel = '0;
        sel[b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_addr_decoder.sv
module bank_addr_decoder
  import bank_dec_pkg::*;
#(
  parameter int ADDR_W = DEC_ADDR_W,
  parameter int NBANK  = DEC_NBANK,
  localparam int NWIN  = NBANK - 1,
  localparam int IDX_W = $clog2(NBANK),
  localparam int SZ_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_we,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [SZ_W-1:0]   win_szlog,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NBANK-1:0]  out_cs,
  output logic              out_force_imm,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_write
);
  logic [NWIN-1:0]   r_en;
  logic [ADDR_W-1:0] r_base  [NWIN];
  logic [SZ_W-1:0]   r_szlog [NWIN];
  logic [NWIN-1:0]   hit, upper;
  logic [NBANK-1:0]  sel;
  logic              force_imm;
  logic              accept;

  bank_window_regs #(.ADDR_W(ADDR_W), .NWIN(NWIN), .IDX_W(IDX_W), .SZ_W(SZ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(win_we), .idx(win_idx), .en_in(win_en),
    .base_in(win_base), .szlog_in(win_szlog),
    .win_en(r_en), .win_base(r_base), .win_szlog(r_szlog)
  );

  bank_window_match #(.ADDR_W(ADDR_W), .NWIN(NWIN), .SZ_W(SZ_W)) u_match (
    .addr(in_addr), .win_en(r_en), .win_base(r_base), .win_szlog(r_szlog),
    .hit(hit), .upper(upper)
  );

  bank_priority_pick #(.NBANK(NBANK)) u_pick (.hit(hit), .sel(sel));

  assign force_imm = in_write && sel[0] && upper[0];
  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_cs        <= '0;
      out_force_imm <= 1'b0;
      out_addr      <= '0;
      out_write     <= 1'b0;
    end else if (accept) begin
      out_valid     <= 1'b1;
      out_cs        <= sel;
      out_force_imm <= force_imm;
      out_addr      <= in_addr;
      out_write     <= in_write;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
      out_cs        <= '0;
      out_force_imm <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_dec_checker.sv
module bank_dec_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [NBANK-1:0] out_cs,
  input logic             out_force_imm,
  input logic             out_write
);
  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_cs) == 1);

  assert_imm_write_bank0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_force_imm |-> (out_write && out_cs[0]));

  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cs) && $stable(out_force_imm)));

  assert_ready_low_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_cs == '0 && !out_force_imm));
endmodule

bind bank_addr_decoder bank_dec_checker #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_cs(out_cs), .out_force_imm(out_force_imm),
  .out_write(out_write)
);

// File: tb/tb_bank_addr_decoder.sv
`timescale 1ns/1ps
module tb_bank_addr_decoder;
  logic        clk = 0, rst_n = 0;
  logic        win_we = 0, win_en = 0;
  logic [1:0]  win_idx = 0;
  logic [31:0] win_base = 0;
  logic [4:0]  win_szlog = 0;
  logic        in_valid = 0, in_write = 0, out_ready = 1;
  logic [31:0] in_addr = 0;
  logic        in_ready, out_valid, out_force_imm, out_write;
  logic [3:0]  out_cs;
  logic [31:0] out_addr;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  bank_addr_decoder dut (
    .clk(clk), .rst_n(rst_n), .win_we(win_we), .win_idx(win_idx), .win_en(win_en),
    .win_base(win_base), .win_szlog(win_szlog), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_write(in_write), .out_valid(out_valid), .out_ready(out_ready),
    .out_cs(out_cs), .out_force_imm(out_force_imm), .out_addr(out_addr), .out_write(out_write)
  );

  // {addr[31:0], write, cs[3:0], force_imm}
  localparam int NV = 11;
  localparam logic [37:0] VEC [NV] = '{
    {32'h0000_1004, 1'b1, 4'b0001, 1'b0},  // R3 lower half bank0
    {32'h0000_1804, 1'b1, 4'b0001, 1'b1},  // R7 upper half write
    {32'h0000_1804, 1'b0, 4'b0001, 1'b0},  // R7 read never forced
    {32'h0000_1FFF, 1'b1, 4'b0001, 1'b1},  // R7 top byte
    {32'h0000_1000, 1'b1, 4'b0001, 1'b0},  // R4 overlap, bank0 wins
    {32'h0000_2000, 1'b1, 4'b0010, 1'b0},  // R3 bank1 only
    {32'h0000_0FFF, 1'b0, 4'b0010, 1'b0},  // R3 bank1 below bank0
    {32'h0000_FFFF, 1'b1, 4'b0010, 1'b0},  // R3 bank1 edge
    {32'h0001_0000, 1'b1, 4'b1000, 1'b0},  // R5 just past bank1
    {32'h0002_0010, 1'b1, 4'b1000, 1'b0},  // R6 bank2 disabled
    {32'hFFFF_FFFF, 1'b0, 4'b1000, 1'b0}   // R5 top of space
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_win(logic [1:0] idx, logic en, logic [31:0] base, logic [4:0] sz);
    @(negedge clk);
    win_we = 1; win_idx = idx; win_en = en; win_base = base; win_szlog = sz;
    @(posedge clk);
    @(negedge clk);
    win_we = 0;
  endtask

  task automatic send(logic [31:0] a, logic w);
    @(negedge clk);
    in_valid = 1; in_addr = a; in_write = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1;
    send(32'h0000_1804, 1'b1);
    check("R1 default bank", 64'(out_cs), 64'h8);
    check("R2 out_valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    check("R9 idle cs", 64'({out_valid, out_cs, out_force_imm}), 64'd0);

    wr_win(2'd0, 1'b1, 32'h0000_1000, 5'd12);
    wr_win(2'd1, 1'b1, 32'h0000_0000, 5'd16);
    wr_win(2'd2, 1'b0, 32'h0002_0000, 5'd12);
    wr_win(2'd3, 1'b1, 32'h0001_0000, 5'd16);  // index 3 ignored

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][37:6], VEC[i][5]);
      check($sformatf("R3/R4/R5/R6/R7 cs vec%0d", i), 64'(out_cs), 64'(VEC[i][4:1]));
      check($sformatf("R7 imm vec%0d", i), 64'(out_force_imm), 64'(VEC[i][0]));
    end

    // R6: enabling bank2 makes the same address hit it
    wr_win(2'd2, 1'b1, 32'h0002_0000, 5'd12);
    send(32'h0002_0010, 1'b1);
    check("R6 bank2 enabled", 64'(out_cs), 64'h4);
    // R4/R6: disabling bank0 hands its range to bank1
    wr_win(2'd0, 1'b0, 32'h0000_1000, 5'd12);
    send(32'h0000_1804, 1'b1);
    check("R6 bank0 disabled", 64'({out_cs, out_force_imm}), 64'({4'b0010, 1'b0}));
    wr_win(2'd0, 1'b1, 32'h0000_1000, 5'd12);

    // R8 back-pressure
    out_ready = 0;
    send(32'h0000_1900, 1'b1);
    check("R8 first result", 64'({out_valid, out_cs, out_force_imm}), 64'({1'b1, 4'b0001, 1'b1}));
    check("R8 in_ready low", 64'(in_ready), 64'd0);
    in_valid = 1; in_addr = 32'h0000_3000; in_write = 0;
    repeat (2) @(negedge clk);
    check("R8 held", 64'({out_valid, out_cs, out_force_imm, out_addr}),
          64'({1'b1, 4'b0001, 1'b1, 32'h0000_1900}));
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R8 queued result", 64'({out_valid, out_cs, out_addr}),
          64'({1'b1, 4'b0010, 32'h0000_3000}));
    @(negedge clk);
    check("R9 drained", 64'({out_valid, out_cs}), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule